// File: doc/BRIEF.md
# External Bus Controller Indirect Configuration Port

This block holds the configuration state of an external bus controller and exposes it to a 32-bit register bus through only two register numbers. A write to the first number loads an index register. A read or write of the next number then reaches the internal register that the index selects. The internal space holds per-bank control words, per-bank access-parameter words, a bus error address, two bus error status words and a global configuration word. Memory bus timing and chip-select generation sit elsewhere. Only the indirection, the index decoding and the reset state are built here.

The index is never advanced by the block, so repeated data accesses keep hitting the same internal register until software writes a new index. The two error status words collect error events reported by the controller's datapath. Software clears them by writing ones. The error address word records the address of the first error taken while both status words are clear. Software can read it but not write it.

Top module: `xbc_cfg_port`

## Requirements
- R1: After reset the index register, every bank control word, every access-parameter word, the error address and both status words read 0, the configuration word reads 0x80400000, and `reg_rdata` is 0.
- R2: A write to register number `IDX_REG_NUM` (default 0x012) stores all 32 data bits in the index register. A read of that number returns the stored value.
- R3: With index 0x00+n (n = 0..NBANK-1), register number `IDX_REG_NUM+1` reads and writes bank control word n. With index 0x10+n it reads and writes access-parameter word n. All 32 bits are writable.
- R4: With index 0x23 the data register reads and writes the configuration word, all 32 bits.
- R5: With any index outside {0x00..0x00+NBANK-1, 0x10..0x10+NBANK-1, 0x20..0x23}, a data read returns 0 and a data write changes no register.
- R6: A read of any register number other than the two port numbers returns 0. A write to such a number changes no register.
- R7: The index is not altered by data accesses. Consecutive data reads and writes all reach the same internal register.
- R8: Index 0x20 reads the error address word. Data writes to it are ignored.
- R9: Index 0x21 selects status word 0 and index 0x22 selects status word 1. A data write clears the bits written as 1. A cycle with `err_evt[k]` high ORs `err_bits` into status word k. When a set and a clear hit the same bit in the same cycle, the set wins.
- R10: A cycle with any `err_evt` bit high loads `err_addr` into the error address word only if both status words were 0 before that cycle. Otherwise the word keeps its value.
- R11: A read strobe registers the read result, which appears on `reg_rdata` one clock later. `reg_rdata` then holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_num | input | AW (10) | Register number of the bus access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Registered read data |
| err_evt | input | 2 | Per-status-word error event pulse |
| err_bits | input | DW (32) | Status bits to set on an error event |
| err_addr | input | DW (32) | Failing address offered with an error event |

## Verification
The assertions assume that inputs are idle while reset is held, so the first cycle after reset has no past strobe or error event to explain. They also assume that `reg_wr` and `reg_rd` are never high in the same cycle. They take the error inputs as meaningful only in cycles where `err_evt` is non-zero. The bench drives every strobe and error pulse for exactly one cycle from the falling edge. It never asserts a read and a write together, and it keeps all inputs at 0 throughout reset.

// File: rtl/xcp_pkg.sv
// Package: shared index map and reset constants of the indirect
// configuration port. Assumes NBANK never exceeds 16, so that the two
// bank windows do not overlap.
package xcp_pkg;
    localparam int XCP_IDX_CTRL_BASE = 'h00;
    localparam int XCP_IDX_ACC_BASE  = 'h10;
    localparam int XCP_IDX_EADDR     = 'h20;
    localparam int XCP_IDX_STAT0     = 'h21;
    localparam int XCP_IDX_STAT1     = 'h22;
    localparam int XCP_IDX_CFG       = 'h23;
    localparam logic [31:0] XCP_CFG_RST = 32'h8040_0000;

    // Which internal register a given index value lands on.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_ACC,
        SEL_EADDR,
        SEL_STAT0,
        SEL_STAT1,
        SEL_CFG
    } xcp_sel_e;
endpackage

// File: rtl/xcp_index_reg.sv
// Module: index (address) register of the indirect port.
// Loads the full data word when the bus writes the index register number.
// Assumes: one-cycle write strobes. It never changes the index on its own.
module xcp_index_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] idx_q
);
    // Hold the index; reload it only on an explicit write.
    always_ff @(posedge clk) begin
        if (!rst_n)  idx_q <= '0;
        else if (we) idx_q <= wdata;
    end
endmodule

// File: rtl/xcp_bank_file.sv
// Module: per-bank control and access-parameter words.
// Each bank has two full-width words, written by one-hot enables.
// Assumes: at most one enable is high per cycle (the decoder guarantees this).
module xcp_bank_file #(
    parameter int DW    = 32,
    parameter int NBANK = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NBANK-1:0]           ctrl_we,
    input  logic [NBANK-1:0]           acc_we,
    input  logic [DW-1:0]              wdata,
    output logic [NBANK-1:0][DW-1:0]   ctrl_q,
    output logic [NBANK-1:0][DW-1:0]   acc_q
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Bank control word b: reset to zero, full overwrite on write.
        always_ff @(posedge clk) begin
            if (!rst_n)          ctrl_q[b] <= '0;
            else if (ctrl_we[b]) ctrl_q[b] <= wdata;
        end

        // Access-parameter word b: reset to zero, full overwrite on write.
        always_ff @(posedge clk) begin
            if (!rst_n)         acc_q[b] <= '0;
            else if (acc_we[b]) acc_q[b] <= wdata;
        end
    end
endmodule

// File: rtl/xcp_err_unit.sv
// Module: bus error capture, with two sticky status words and one error address.
// Status bits are set by hardware events and cleared by writing ones; a set wins
// over a clear on the same bit. The address is captured only while both status
// words are clear, so it keeps the first error. Assumes err_bits and err_addr
// are meaningful only when err_evt is non-zero.
module xcp_err_unit #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    err_evt,
    input  logic [DW-1:0] err_bits,
    input  logic [DW-1:0] err_addr,
    input  logic [1:0]    clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] eaddr_q,
    output logic [1:0][DW-1:0] stat_q
);
    logic all_clear;

    // Both status words empty: the next error is the first one.
    always_comb all_clear = (stat_q[0] == '0) && (stat_q[1] == '0);

    for (genvar k = 0; k < 2; k++) begin : g_stat
        // Status word k: write-one-to-clear, then OR in the event bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[k] <= '0;
            end else begin
                stat_q[k] <= (stat_q[k] & ~(clr_we[k] ? wdata : '0))
                           | (err_evt[k] ? err_bits : '0);
            end
        end
    end

    // Error address: capture on the first error only; read-only to the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                       eaddr_q <= '0;
        else if ((|err_evt) && all_clear) eaddr_q <= err_addr;
    end
endmodule

// File: rtl/xbc_cfg_port.sv
// Module: top of the indirect configuration port.
// Decodes the two bus register numbers, classifies the stored index, routes
// data writes to the selected internal register and registers read data.
// Assumes: reg_wr and reg_rd are single-cycle and never high together.
module xbc_cfg_port
    import xcp_pkg::*;
#(
    parameter int          AW          = 10,
    parameter int          DW          = 32,
    parameter int          NBANK       = 8,
    parameter logic [9:0]  IDX_REG_NUM = 10'h012
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_num,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [1:0]    err_evt,
    input  logic [DW-1:0] err_bits,
    input  logic [DW-1:0] err_addr
);
    localparam logic [AW-1:0] NUM_IDX = AW'(IDX_REG_NUM);
    localparam logic [AW-1:0] NUM_DAT = AW'(IDX_REG_NUM) + AW'(1);

    logic                     hit_idx, hit_dat;
    logic [DW-1:0]            idx_q;
    logic [NBANK-1:0]         sel_ctrl, sel_acc;
    xcp_sel_e                 sel;
    logic                     dat_wr;
    logic [NBANK-1:0][DW-1:0] ctrl_q, acc_q;
    logic [DW-1:0]            eaddr_q, cfg_q;
    logic [1:0][DW-1:0]       stat_q;
    logic [DW-1:0]            bank_rd, rd_mux;

    // Which of the two port registers the current access addresses.
    always_comb begin
        hit_idx = (reg_num == NUM_IDX);
        hit_dat = (reg_num == NUM_DAT);
        dat_wr  = reg_wr && hit_dat;
    end

    xcp_index_reg #(.DW(DW)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_wr && hit_idx),
        .wdata (reg_wdata),
        .idx_q (idx_q)
    );

    // One-hot bank match of the stored index, per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_dec
        always_comb begin
            sel_ctrl[b] = (idx_q == DW'(XCP_IDX_CTRL_BASE + b));
            sel_acc[b]  = (idx_q == DW'(XCP_IDX_ACC_BASE + b));
        end
    end

    // Classify the index into one internal register kind.
    always_comb begin
        if (|sel_ctrl)                         sel = SEL_CTRL;
        else if (|sel_acc)                     sel = SEL_ACC;
        else if (idx_q == DW'(XCP_IDX_EADDR))  sel = SEL_EADDR;
        else if (idx_q == DW'(XCP_IDX_STAT0))  sel = SEL_STAT0;
        else if (idx_q == DW'(XCP_IDX_STAT1))  sel = SEL_STAT1;
        else if (idx_q == DW'(XCP_IDX_CFG))    sel = SEL_CFG;
        else                                   sel = SEL_NONE;
    end

    xcp_bank_file #(.DW(DW), .NBANK(NBANK)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (dat_wr ? sel_ctrl : '0),
        .acc_we  (dat_wr ? sel_acc  : '0),
        .wdata   (reg_wdata),
        .ctrl_q  (ctrl_q),
        .acc_q   (acc_q)
    );

    xcp_err_unit #(.DW(DW)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_evt  (err_evt),
        .err_bits (err_bits),
        .err_addr (err_addr),
        .clr_we   ({dat_wr && (sel == SEL_STAT1), dat_wr && (sel == SEL_STAT0)}),
        .wdata    (reg_wdata),
        .eaddr_q  (eaddr_q),
        .stat_q   (stat_q)
    );

    // Configuration word: full overwrite through the data register.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cfg_q <= DW'(XCP_CFG_RST);
        else if (dat_wr && sel == SEL_CFG) cfg_q <= reg_wdata;
    end

    // OR-reduce the selected bank words (at most one select is high).
    always_comb begin
        bank_rd = '0;
        for (int b = 0; b < NBANK; b++) begin
            bank_rd = bank_rd | (sel_ctrl[b] ? ctrl_q[b] : '0)
                              | (sel_acc[b]  ? acc_q[b]  : '0);
        end
    end

    // Read result: index register, the selected internal register, or zero.
    always_comb begin
        rd_mux = '0;
        if (hit_idx) begin
            rd_mux = idx_q;
        end else if (hit_dat) begin
            unique case (sel)
                SEL_CTRL, SEL_ACC: rd_mux = bank_rd;
                SEL_EADDR:         rd_mux = eaddr_q;
                SEL_STAT0:         rd_mux = stat_q[0];
                SEL_STAT1:         rd_mux = stat_q[1];
                SEL_CFG:           rd_mux = cfg_q;
                default:           rd_mux = '0;
            endcase
        end
    end

    // Register read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/xcp_checker.sv
// Module: property checker for xbc_cfg_port, attached with bind.
// Assumes inputs are idle during reset and strobes are single-cycle.
module xcp_checker #(
    parameter int         AW          = 10,
    parameter int         DW          = 32,
    parameter int         NBANK       = 8,
    parameter logic [9:0] IDX_REG_NUM = 10'h012
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_num,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [1:0]    err_evt,
    input logic [DW-1:0] err_bits,
    input logic [DW-1:0] err_addr,
    input logic [DW-1:0] idx_q,
    input logic [DW-1:0] eaddr_q,
    input logic [DW-1:0] stat0_q,
    input logic [DW-1:0] stat1_q
);
    logic idx_known;

    // Independent range check of the defined index set.
    always_comb begin
        idx_known = (idx_q < DW'(NBANK))
                 || (idx_q >= DW'(16) && idx_q < DW'(16 + NBANK))
                 || (idx_q >= DW'(32) && idx_q <= DW'(35));
    end

    // R2: an index write is visible in the index register next cycle.
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_num == AW'(IDX_REG_NUM)) |=> (idx_q == $past(reg_wdata)));

    // R5: a data read with an undefined index returns zero.
    a_r5_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_num == AW'(IDX_REG_NUM) + AW'(1) && !idx_known) |=> (reg_rdata == '0));

    // R6: a read of a foreign register number returns zero.
    a_r6_foreign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_num != AW'(IDX_REG_NUM) && reg_num != AW'(IDX_REG_NUM) + AW'(1))
        |=> (reg_rdata == '0));

    // R7: data accesses never move the index.
    a_r7_no_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_num == AW'(IDX_REG_NUM)) |=> $stable(idx_q));

    // R9: event bits are set in the status word after the event (set wins).
    a_r9_stat0_set: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt[0] |=> ((stat0_q & $past(err_bits)) == $past(err_bits)));
    a_r9_stat1_set: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt[1] |=> ((stat1_q & $past(err_bits)) == $past(err_bits)));

    // R10: the first error (both words clear) captures its address.
    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ((|err_evt) && stat0_q == '0 && stat1_q == '0) |=> (eaddr_q == $past(err_addr)));

    // R8 / R10: with any status pending, the error address is frozen.
    a_r8_eaddr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0_q != '0 || stat1_q != '0) |=> $stable(eaddr_q));

    // R11: without a read strobe the read data holds.
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind xbc_cfg_port xcp_checker #(
    .AW(AW), .DW(DW), .NBANK(NBANK), .IDX_REG_NUM(IDX_REG_NUM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_num   (reg_num),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .err_evt   (err_evt),
    .err_bits  (err_bits),
    .err_addr  (err_addr),
    .idx_q     (idx_q),
    .eaddr_q   (eaddr_q),
    .stat0_q   (stat_q[0]),
    .stat1_q   (stat_q[1])
);

// File: tb/tb_xbc_cfg_port.sv
// Directed bench for xbc_cfg_port: one task per scenario, each self-checking.
module tb_xbc_cfg_port;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int NB = 8;
    localparam logic [AW-1:0] N_IDX = 10'h012;
    localparam logic [AW-1:0] N_DAT = 10'h013;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_num = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [1:0]    err_evt = '0;
    logic [DW-1:0] err_bits = '0;
    logic [DW-1:0] err_addr = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;   // 250 MHz

    xbc_cfg_port #(.AW(AW), .DW(DW), .NBANK(NB)) dut (
        .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_evt(err_evt), .err_bits(err_bits), .err_addr(err_addr)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] num, input logic [DW-1:0] d);
        @(negedge clk);
        reg_num = num; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Read data is registered: it is sampled at the falling edge after the strobe edge.
    task automatic bus_read(input logic [AW-1:0] num, output logic [DW-1:0] d);
        @(negedge clk);
        reg_num = num; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idx_read(input logic [DW-1:0] idx, output logic [DW-1:0] d);
        bus_write(N_IDX, idx);
        bus_read(N_DAT, d);
    endtask

    task automatic idx_write(input logic [DW-1:0] idx, input logic [DW-1:0] v);
        bus_write(N_IDX, idx);
        bus_write(N_DAT, v);
    endtask

    task automatic err_pulse(input logic [1:0] ev, input logic [DW-1:0] bits, input logic [DW-1:0] a);
        @(negedge clk);
        err_evt = ev; err_bits = bits; err_addr = a;
        @(negedge clk);
        err_evt = '0; err_bits = '0; err_addr = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check("R1 rdata after reset", reg_rdata, '0);
        bus_read(N_IDX, v);        check("R1 index reset", v, '0);
        idx_read(32'h23, v);       check("R1 cfg reset", v, 32'h8040_0000);
        idx_read(32'h03, v);       check("R1 ctrl3 reset", v, '0);
        idx_read(32'h17, v);       check("R1 acc7 reset", v, '0);
        idx_read(32'h20, v);       check("R1 eaddr reset", v, '0);
        idx_read(32'h21, v);       check("R1 stat0 reset", v, '0);
        idx_read(32'h22, v);       check("R1 stat1 reset", v, '0);
    endtask

    task automatic t_index();
        logic [DW-1:0] v;
        bus_write(N_IDX, 32'hDEAD_0017);
        bus_read(N_IDX, v);        check("R2 index readback", v, 32'hDEAD_0017);
        bus_write(N_IDX, 32'h0000_0005);
        bus_read(N_IDX, v);        check("R2 index rewrite", v, 32'h0000_0005);
    endtask

    task automatic t_banks();
        logic [DW-1:0] v;
        for (int i = 0; i < NB; i++) begin
            idx_write(32'(i), 32'hC000_0000 | 32'(i * 32'h0101));
            idx_write(32'(16 + i), 32'h0A00_0000 ^ 32'(i * 32'h1111_0003));
        end
        for (int i = 0; i < NB; i++) begin
            idx_read(32'(i), v);
            check("R3 bank ctrl", v, 32'hC000_0000 | 32'(i * 32'h0101));
            idx_read(32'(16 + i), v);
            check("R3 bank access", v, 32'h0A00_0000 ^ 32'(i * 32'h1111_0003));
        end
    endtask

    task automatic t_cfg();
        logic [DW-1:0] v;
        idx_write(32'h23, 32'h1234_ABCD);
        idx_read(32'h23, v);       check("R4 cfg write", v, 32'h1234_ABCD);
    endtask

    task automatic t_undef();
        logic [DW-1:0] v;
        idx_write(32'h08, 32'hFFFF_FFFF);
        bus_read(N_DAT, v);        check("R5 undef 0x08 reads 0", v, '0);
        idx_write(32'h24, 32'hFFFF_FFFF);
        bus_read(N_DAT, v);        check("R5 undef 0x24 reads 0", v, '0);
        idx_write(32'h100, 32'hFFFF_FFFF);
        bus_read(N_DAT, v);        check("R5 undef 0x100 reads 0", v, '0);
        idx_read(32'h07, v);       check("R5 ctrl7 untouched", v, 32'hC000_0707);
        idx_read(32'h10, v);       check("R5 acc0 untouched", v, 32'h0A00_0000);
        idx_read(32'h23, v);       check("R5 cfg untouched", v, 32'h1234_ABCD);
    endtask

    task automatic t_other();
        logic [DW-1:0] v;
        bus_write(N_IDX, 32'h02);
        bus_write(10'h011, 32'h5555_5555);
        bus_write(10'h014, 32'h6666_6666);
        bus_read(10'h011, v);      check("R6 foreign 0x011 reads 0", v, '0);
        bus_read(10'h3FF, v);      check("R6 foreign 0x3FF reads 0", v, '0);
        bus_read(N_IDX, v);        check("R6 index untouched", v, 32'h02);
        bus_read(N_DAT, v);        check("R6 ctrl2 untouched", v, 32'hC000_0202);
    endtask

    task automatic t_noinc();
        logic [DW-1:0] v;
        bus_write(N_IDX, 32'h04);
        bus_write(N_DAT, 32'h1111_1111);
        bus_write(N_DAT, 32'h2222_2222);
        bus_read(N_DAT, v);        check("R7 same reg after two writes", v, 32'h2222_2222);
        bus_read(N_DAT, v);        check("R7 same reg on second read", v, 32'h2222_2222);
        bus_read(N_IDX, v);        check("R7 index not advanced", v, 32'h04);
        idx_read(32'h05, v);       check("R7 neighbour untouched", v, 32'hC000_0505);
    endtask

    task automatic t_errors();
        logic [DW-1:0] v;
        idx_write(32'h20, 32'h7777_7777);
        bus_read(N_DAT, v);        check("R8 eaddr ignores write", v, '0);
        err_pulse(2'b01, 32'h5, 32'h0000_1234);
        idx_read(32'h21, v);       check("R9 stat0 set", v, 32'h5);
        idx_read(32'h20, v);       check("R10 first error captured", v, 32'h0000_1234);
        err_pulse(2'b10, 32'h2, 32'h0000_9999);
        idx_read(32'h22, v);       check("R9 stat1 set", v, 32'h2);
        idx_read(32'h20, v);       check("R10 later error not captured", v, 32'h0000_1234);
        idx_write(32'h21, 32'h1);
        bus_read(N_DAT, v);        check("R9 W1C clears only written ones", v, 32'h4);
        // Same-cycle clear and set of bit 2 in status word 0.
        @(negedge clk);
        reg_num = N_DAT; reg_wdata = 32'h4; reg_wr = 1'b1;
        err_evt = 2'b01; err_bits = 32'h4; err_addr = 32'hBAD0_0000;
        @(negedge clk);
        reg_wr = 1'b0; err_evt = '0; err_bits = '0; err_addr = '0;
        bus_read(N_DAT, v);        check("R9 set wins over clear", v, 32'h4);
        idx_read(32'h20, v);       check("R10 no capture while pending", v, 32'h0000_1234);
        idx_write(32'h21, 32'hFFFF_FFFF);
        idx_write(32'h22, 32'hFFFF_FFFF);
        idx_read(32'h22, v);       check("R9 stat1 cleared", v, '0);
        err_pulse(2'b01, 32'h8, 32'h0000_ABCD);
        idx_read(32'h20, v);       check("R10 capture after clear", v, 32'h0000_ABCD);
        idx_write(32'h20, 32'h0);
        bus_read(N_DAT, v);        check("R8 eaddr read-only", v, 32'h0000_ABCD);
    endtask

    task automatic t_rd_hold();
        logic [DW-1:0] v;
        idx_read(32'h23, v);       check("R11 read value", v, 32'h1234_ABCD);
        bus_write(N_DAT, 32'h0BAD_F00D);
        repeat (3) @(negedge clk);
        check("R11 rdata held without strobe", reg_rdata, 32'h1234_ABCD);
        bus_read(N_DAT, v);        check("R11 next read updates", v, 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_banks();
        t_cfg();
        t_undef();
        t_other();
        t_noinc();
        t_errors();
        t_rd_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule